// File: doc/BRIEF.md
# MLT-3 Transmit Serializer

This block is the transmit datapath of a 100 Mb/s copper physical layer. Everything runs on one fast bit clock. From that clock the block derives a nibble-rate strobe by dividing by five and drives it out, so that the code-group source upstream can pace itself. At each rising edge of that strobe the block captures a 5-bit code group into a holding register.

One bit-clock cycle later the group moves into a parallel-in serial-out shifter. The shifter sends bit 0 first. The serial stream leaving the last shifter stage passes through an NRZ-to-NRZI converter. The NRZI level then drives a three-level MLT-3 sequencer, whose 2-bit signed code is handed to the analog line driver together with a drive enable.

A mode input selects high-speed operation. When the mode input is low, the line is parked at the zero level and the driver is disabled. The serializer and NRZI state keep running in that mode, so returning to high-speed operation produces no spurious step.

Top module: `mlt3_serial_tx`

## Requirements
- R1: `nib_clk_o` is a registered strobe with a period of GROUP_W bit-clock cycles. It is high for the first (GROUP_W+1)/2 cycles of each period (3 of 5 by default). After reset it is high, in phase 0, and its first rising edge comes GROUP_W edges after reset is released.
- R2: `code_i` is sampled only at the clock edge on which `nib_clk_o` rises. A change of `code_i` at any other time has no effect on the transmitted symbols.
- R3: Bits go out least significant first. Groups are sent back to back with no gap between them. Bit k of a group captured at edge C affects `mlt_o` after edge C+3+k, where edge C+1 moves the group from the holding register into the shifter.
- R4: The NRZI level toggles for a serial 1 and holds for a serial 0. As a result, a 0 bit leaves `mlt_o` unchanged and a 1 bit moves it exactly one step.
- R5: `mlt_o` steps through the repeating cycle 0, +1, 0, −1 and never jumps directly between +1 and −1. The encodings are 2'b00 for 0, 2'b01 for +1 and 2'b11 for −1. The code 2'b10 never appears.
- R6: At each clock edge, `drive_en_o` takes the value of `fast_mode_i`. While `fast_mode_i` is sampled low, `mlt_o` is 2'b00 and the cycle is reset so that the next step goes to +1.
- R7: A synchronous active-high `rst` clears the holding register, the shifter and the NRZI state. It also sets `mlt_o` to 0 with +1 as the next step, sets `drive_en_o` low, and restarts the strobe divider at phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (five times the group rate) |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode_i | input | 1 | High selects 100 Mb/s transmission; low parks the line |
| code_i | input | GROUP_W | Code group, sampled at the strobe's rising edge |
| nib_clk_o | output | 1 | Divided group-rate strobe |
| mlt_o | output | 2 | MLT-3 symbol: 00 = 0, 01 = +1, 11 = −1 |
| drive_en_o | output | 1 | Line driver enable |

## Verification
The bench builds the block with the default GROUP_W of 5. With that odd ratio, the strobe has an uneven three-high, two-low duty, and the bench checks that duty every cycle. Because the groups are five bits wide, each of the five bit positions can be hit with a lone 1. This separates the LSB-first order and the exact C+3+k latency from a shifted or reversed variant. Runs of all-ones groups drive the MLT-3 sequencer through its full four-step cycle several times. This covers the step from +1 back to 0 and the step into −1, together with the mode-drop and mid-stream reset cases.

// File: rtl/mlt3_tx_pkg.sv
package mlt3_tx_pkg;

    localparam int DEF_GROUP_W = 5;

    // Output symbol encoding seen by the line driver
    typedef enum logic [1:0] {
        MLT_ZERO = 2'b00,
        MLT_POS  = 2'b01,
        MLT_NEG  = 2'b11
    } mlt_level_e;

    // Position in the four-step MLT-3 cycle
    typedef enum logic [1:0] {
        CYC_ZERO_UP   = 2'd0,
        CYC_HIGH      = 2'd1,
        CYC_ZERO_DOWN = 2'd2,
        CYC_LOW       = 2'd3
    } cycle_pos_e;

    typedef struct packed {
        cycle_pos_e pos;
        logic       drive;
    } seq_state_t;

    function automatic cycle_pos_e next_pos(input cycle_pos_e p);
        case (p)
            CYC_ZERO_UP:   next_pos = CYC_HIGH;
            CYC_HIGH:      next_pos = CYC_ZERO_DOWN;
            CYC_ZERO_DOWN: next_pos = CYC_LOW;
            default:       next_pos = CYC_ZERO_UP;
        endcase
    endfunction

    function automatic mlt_level_e level_of(input cycle_pos_e p);
        case (p)
            CYC_HIGH: level_of = MLT_POS;
            CYC_LOW:  level_of = MLT_NEG;
            default:  level_of = MLT_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/tx_phase_gen.sv
module tx_phase_gen #(
    parameter int GROUP_W = mlt3_tx_pkg::DEF_GROUP_W
) (
    input  logic clk,
    input  logic rst,
    output logic capture_o,
    output logic load_o,
    output logic nib_clk_o
);
    localparam int PW     = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
    localparam int HI_CYC = (GROUP_W + 1) / 2;
    localparam logic [PW-1:0] LAST = PW'(GROUP_W - 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_n;
    logic          nib_q;

    always_comb begin
        if (phase_q == LAST) phase_n = '0;
        else                 phase_n = phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            nib_q   <= 1'b1;
        end else begin
            phase_q <= phase_n;
            nib_q   <= (int'(phase_n) < HI_CYC);
        end
    end

    // Capture happens on the edge that enters phase 0 (strobe rising edge)
    assign capture_o = (phase_q == LAST);
    // Shifter reload on the edge leaving phase 0
    assign load_o    = (phase_q == '0);
    assign nib_clk_o = nib_q;

endmodule

// File: rtl/tx_piso_nrzi.sv
module tx_piso_nrzi #(
    parameter int GROUP_W = mlt3_tx_pkg::DEF_GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture_i,
    input  logic               load_i,
    input  logic [GROUP_W-1:0] code_i,
    output logic               nrzi_o
);
    logic [GROUP_W-1:0] hold_q;
    logic [GROUP_W-1:0] shift_q;
    logic [GROUP_W-1:0] shift_adv;
    logic               nrzi_q;

    // Shift toward bit 0; bit 0 is the serial output
    genvar gi;
    generate
        for (gi = 0; gi < GROUP_W; gi++) begin : g_adv
            if (gi == GROUP_W - 1) begin : g_top
                assign shift_adv[gi] = 1'b0;
            end else begin : g_mid
                assign shift_adv[gi] = shift_q[gi+1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
            nrzi_q  <= 1'b0;
        end else begin
            if (capture_i) hold_q <= code_i;
            if (load_i)    shift_q <= hold_q;
            else           shift_q <= shift_adv;
            // NRZ to NRZI at the last shifter stage
            nrzi_q <= nrzi_q ^ shift_q[0];
        end
    end

    assign nrzi_o = nrzi_q;

endmodule

// File: rtl/tx_mlt3_seq.sv
module tx_mlt3_seq
    import mlt3_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic       nrzi_i,
    output logic [1:0] mlt_o,
    output logic       drive_en_o
);
    seq_state_t seq_q;
    seq_state_t seq_n;
    logic       last_q;

    always_comb begin
        seq_n = seq_q;
        if (!mode_i) begin
            seq_n.pos   = CYC_ZERO_UP;
            seq_n.drive = 1'b0;
        end else begin
            seq_n.drive = 1'b1;
            if (nrzi_i != last_q) seq_n.pos = next_pos(seq_q.pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.pos   <= CYC_ZERO_UP;
            seq_q.drive <= 1'b0;
            last_q      <= 1'b0;
        end else begin
            seq_q  <= seq_n;
            last_q <= nrzi_i;
        end
    end

    assign mlt_o      = level_of(seq_q.pos);
    assign drive_en_o = seq_q.drive;

endmodule

// File: rtl/mlt3_serial_tx.sv
module mlt3_serial_tx #(
    parameter int GROUP_W = mlt3_tx_pkg::DEF_GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fast_mode_i,
    input  logic [GROUP_W-1:0] code_i,
    output logic               nib_clk_o,
    output logic [1:0]         mlt_o,
    output logic               drive_en_o
);
    logic capture;
    logic load;
    logic nrzi;

    tx_phase_gen #(.GROUP_W(GROUP_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .capture_o (capture),
        .load_o    (load),
        .nib_clk_o (nib_clk_o)
    );

    tx_piso_nrzi #(.GROUP_W(GROUP_W)) u_piso (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .load_i    (load),
        .code_i    (code_i),
        .nrzi_o    (nrzi)
    );

    tx_mlt3_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (fast_mode_i),
        .nrzi_i     (nrzi),
        .mlt_o      (mlt_o),
        .drive_en_o (drive_en_o)
    );

endmodule

// File: rtl/mlt3_tx_checks.sv
module mlt3_tx_checks (
    input logic       clk,
    input logic       rst,
    input logic       fast_mode_i,
    input logic       nib_clk_o,
    input logic [1:0] mlt_o,
    input logic       drive_en_o
);
    // R1
    strobe_high_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nib_clk_o) |=> nib_clk_o);

    // R1
    strobe_low_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nib_clk_o) |=> !nib_clk_o);

    // R5
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        mlt_o != 2'b10);

    // R5
    no_jump_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mlt_o) |-> ($past(mlt_o) == 2'b00 || mlt_o == 2'b00));

    // R6
    park_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_en_o |-> mlt_o == 2'b00);

    // R6
    drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> drive_en_o == $past(fast_mode_i));

endmodule

bind mlt3_serial_tx mlt3_tx_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .fast_mode_i (fast_mode_i),
    .nib_clk_o   (nib_clk_o),
    .mlt_o       (mlt_o),
    .drive_en_o  (drive_en_o)
);

// File: tb/sim_mlt3_serial_tx.sv
`timescale 1ns/1ps
module sim_mlt3_serial_tx;
    localparam int W  = 5;
    localparam int HI = (W + 1) / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fast_mode = 1'b1;
    logic [W-1:0] code = '0;
    logic         nib_clk;
    logic [1:0]   mlt;
    logic         drive_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int epos     = 0;
    logic mode_s = 1'b0;
    logic started = 1'b0;
    logic exp_v [64];
    logic exp_b [64];
    string cur_tag = "R7";

    always #2.5 clk = ~clk;

    mlt3_serial_tx #(.GROUP_W(W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .fast_mode_i (fast_mode),
        .code_i      (code),
        .nib_clk_o   (nib_clk),
        .mlt_o       (mlt),
        .drive_en_o  (drive_en)
    );

    function automatic logic [1:0] lvl(input int p);
        case (p % 4)
            1:       lvl = 2'b01;
            3:       lvl = 2'b11;
            default: lvl = 2'b00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model from the requirements, updated at each clock edge
    always @(posedge clk) begin
        int n;
        started <= 1'b1;
        if (rst) begin
            for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
            epos   = 0;
            mode_s = 1'b0;
            cyc    <= 0;
        end else begin
            n = cyc + 1;
            mode_s = fast_mode;
            if (exp_v[n % 64]) begin
                if (exp_b[n % 64] && mode_s) epos = epos + 1;
                exp_v[n % 64] = 1'b0;
            end
            if (!mode_s) epos = 0;
            if (n % W == 0) begin
                for (int k = 0; k < W; k++) begin
                    exp_v[(n + 3 + k) % 64] = 1'b1;
                    exp_b[(n + 3 + k) % 64] = code[k];
                end
            end
            cyc <= n;
        end
    end

    // Continuous comparison away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check("R1 strobe", {31'd0, nib_clk}, {31'd0, ((cyc % W) < HI)});
            check({cur_tag, " symbol"}, {30'd0, mlt}, {30'd0, lvl(epos)});
            check("R6 drive enable", {31'd0, drive_en}, {31'd0, mode_s});
        end
    end

    task automatic send(input logic [W-1:0] c);
        do @(negedge clk); while (cyc % W != W - 1);
        code = c;
    endtask

    task automatic flush();
        send('0);
        send('0);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        cur_tag = "R7";
        repeat (3) @(negedge clk);
        check("R7 reset symbol", {30'd0, mlt}, 32'd0);
        check("R7 reset drive", {31'd0, drive_en}, 32'd0);
        check("R7 reset strobe", {31'd0, nib_clk}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R6 drive after reset", {31'd0, drive_en}, 32'd1);
        flush();
    endtask

    task automatic t_all_ones();
        cur_tag = "R5";
        repeat (4) send('1);
        flush();
    endtask

    task automatic t_bit_order();
        cur_tag = "R3";
        for (int b = 0; b < W; b++) begin
            send(W'(1) << b);
            send('0);
        end
        send(5'b01100);
        send(5'b10001);
        flush();
    endtask

    task automatic t_nrzi();
        cur_tag = "R4";
        send(5'b10101);
        send(5'b01010);
        send(5'b11011);
        send(5'b00100);
        flush();
    endtask

    task automatic t_hold_ignore();
        cur_tag = "R2";
        send(5'b00011);
        repeat (2) @(negedge clk);
        code = 5'b11100;
        send(5'b01000);
        repeat (3) @(negedge clk);
        code = 5'b10111;
        flush();
    endtask

    task automatic t_mode();
        cur_tag = "R6";
        send('1);
        repeat (2) @(negedge clk);
        fast_mode = 1'b0;
        @(negedge clk);
        check("R6 parked symbol", {30'd0, mlt}, 32'd0);
        check("R6 parked drive", {31'd0, drive_en}, 32'd0);
        send('1);
        send('1);
        fast_mode = 1'b1;
        send('1);
        send('1);
        flush();
    endtask

    task automatic t_mid_reset();
        cur_tag = "R7";
        send('1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid reset symbol", {30'd0, mlt}, 32'd0);
        check("R7 mid reset strobe", {31'd0, nib_clk}, 32'd1);
        check("R7 mid reset drive", {31'd0, drive_en}, 32'd0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        send('0);
        send(5'b00001);
        flush();
    endtask

    initial begin
        t_reset();
        t_all_ones();
        t_bit_order();
        t_nrzi();
        t_hold_ignore();
        t_mode();
        t_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule